// File: doc/BRIEF.md
# Three-Phase Hall Commutation Decoder

This block turns the three Hall sensor bits of a brushless motor into gate enables for three half-bridges. It first passes the Hall code through a glitch filter: a new code must stay on the inputs for a programmable number of clock edges before it becomes the accepted code. It then decodes the accepted code, together with a direction select, into one of three drive levels per phase. A phase can be driven high (upper switch), driven low (lower switch) or left floating (both switches off).

The per-phase gate stage combines the drive level with a PWM input and a synchronous-rectify input. It also applies two protection inputs. A drive-permit input covers stop, undervoltage and start-up reset, and switches everything off when low. A thermal-fault input removes only the upper switches. Dead-time insertion and the analog Hall front end sit outside this block.

The filter is a two-state machine. In LOCKED the accepted code equals the input. In QUALIFY a candidate code is being counted. Its transitions are:
- LOCKED to QUALIFY (a differing code appears),
- QUALIFY to LOCKED by accept (the count reaches the programmed length),
- QUALIFY to LOCKED by abandon (the input returns to the accepted code),
- QUALIFY to QUALIFY by restart (a third code replaces the candidate).

A length of 1 accepts a new code straight from LOCKED.

Top module: `hall_commutator`

## Requirements
- R1: Hall bits are hall_i[2]=sensor 1, hall_i[1]=sensor 2, hall_i[0]=sensor 3. Gate bit 2 drives phase 1, bit 1 drives phase 2 and bit 0 drives phase 3. With dir_i=0, the accepted codes map to phase levels (phase 1, 2, 3) as follows (H=high, L=low, F=float):
  - 101 gives L,H,F
  - 100 gives L,F,H
  - 110 gives F,L,H
  - 010 gives H,L,F
  - 011 gives H,F,L
  - 001 gives F,H,L
- R2: With dir_i=1, the decoder uses the bitwise complement of the accepted code in the R1 table.
- R3: A high phase has its upper enable equal to pwm_i and its lower enable equal to (not pwm_i) and rect_i.
- R4: A low phase has its lower enable on and its upper enable off. A floating phase has both enables off.
- R5: Accepted codes 000 and 111 turn off all six enables.
- R6: While permit_i is 0, all six enables are off.
- R7: While therm_i is 1, all upper enables are off and the lower enables are unchanged.
- R8: A new Hall code present at L consecutive rising edges becomes the accepted code at the L-th edge, where L = filt_len_i. A value of 0 is treated as 1.
- R9: A new code held for fewer than L edges has no effect on the outputs. A different code arriving during qualification restarts the count.
- R10: After reset the accepted code is 000, so all enables are off.
- R11: No phase ever has both enables on, and at most one upper enable is on at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| filt_len_i | input | CNT_W | Edges a new Hall code must persist (0 acts as 1) |
| hall_i | input | 3 | Synchronized Hall bits, bit 2 = sensor 1 |
| dir_i | input | 1 | Direction select, 1 complements the code |
| pwm_i | input | 1 | PWM for the high-driven phase |
| rect_i | input | 1 | Synchronous-rectify enable during PWM off time |
| permit_i | input | 1 | Drive permit, 0 forces all switches off |
| therm_i | input | 1 | Thermal fault, 1 forces upper switches off |
| hi_en_o | output | 3 | Upper switch enables, bit 2 = phase 1 |
| lo_en_o | output | 3 | Lower switch enables, bit 2 = phase 1 |

## Verification
Only the accepted code and the filter count hold state. An error there shows at the gate outputs on the very edge where a code should have been taken or kept. A premature accept changes the enables one or more edges before the L-th edge. A missed or dropped restart lets a glitch reach the phases. A stale code leaves the old enable pattern in place after the L-th edge. The gate path is combinational, so a wrong level or protection decision appears in the same cycle as the stimulus.

// File: rtl/hc_pkg.sv
package hc_pkg;

    localparam int NUM_PH = 3;

    typedef enum logic [1:0] {
        PH_FLOAT = 2'd0,
        PH_HIGH  = 2'd1,
        PH_LOW   = 2'd2
    } phase_e;

    typedef enum logic {
        FS_LOCKED  = 1'b0,
        FS_QUALIFY = 1'b1
    } filt_state_e;

endpackage

// File: rtl/hall_filter.sv
module hall_filter
    import hc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] len_i,
    input  logic [2:0]       hall_i,
    output logic [2:0]       code_o
);

    filt_state_e      state_q, state_d;
    logic [2:0]       acc_q, acc_d;
    logic [2:0]       cand_q, cand_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    logic [CNT_W-1:0] eff_len;
    logic [CNT_W:0]   cnt_next_x;
    logic [CNT_W:0]   eff_len_x;
    logic             len_one;

    // R8: a programmed length of zero behaves as one
    assign eff_len    = (len_i == '0) ? CNT_W'(1) : len_i;
    assign eff_len_x  = {1'b0, eff_len};
    assign cnt_next_x = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    assign len_one    = (eff_len == CNT_W'(1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FS_LOCKED;
            acc_q   <= 3'b000;      // R10
            cand_q  <= 3'b000;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            acc_q   <= acc_d;
            cand_q  <= cand_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        acc_d   = acc_q;
        cand_d  = cand_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            FS_LOCKED: begin
                if (hall_i != acc_q) begin
                    if (len_one) begin
                        acc_d = hall_i;
                    end else begin
                        state_d = FS_QUALIFY;
                        cand_d  = hall_i;
                        cnt_d   = CNT_W'(1);
                    end
                end
            end
            FS_QUALIFY: begin
                if (hall_i == acc_q) begin
                    // abandon: input returned to accepted code (R9)
                    state_d = FS_LOCKED;
                    cnt_d   = '0;
                end else if (hall_i != cand_q) begin
                    // restart on a different code (R9)
                    if (len_one) begin
                        acc_d   = hall_i;
                        state_d = FS_LOCKED;
                        cnt_d   = '0;
                    end else begin
                        cand_d = hall_i;
                        cnt_d  = CNT_W'(1);
                    end
                end else if (cnt_next_x >= eff_len_x) begin
                    // accept at the L-th edge (R8)
                    acc_d   = cand_q;
                    state_d = FS_LOCKED;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_next_x[CNT_W-1:0];
                end
            end
            default: begin
                state_d = FS_LOCKED;
                cnt_d   = '0;
            end
        endcase
    end

    assign code_o = acc_q;

endmodule

// File: rtl/comm_decode.sv
module comm_decode
    import hc_pkg::*;
(
    input  logic [2:0] code_i,
    input  logic       dir_i,
    output phase_e     ph_o [NUM_PH]
);

    logic [2:0] eff;

    // R2: reverse direction reads the complemented code
    assign eff = dir_i ? ~code_i : code_i;

    // R1 table; index 2 is phase 1
    always_comb begin
        ph_o[0] = PH_FLOAT;
        ph_o[1] = PH_FLOAT;
        ph_o[2] = PH_FLOAT;
        unique case (eff)
            3'b101: begin ph_o[2] = PH_LOW;   ph_o[1] = PH_HIGH;  ph_o[0] = PH_FLOAT; end
            3'b100: begin ph_o[2] = PH_LOW;   ph_o[1] = PH_FLOAT; ph_o[0] = PH_HIGH;  end
            3'b110: begin ph_o[2] = PH_FLOAT; ph_o[1] = PH_LOW;   ph_o[0] = PH_HIGH;  end
            3'b010: begin ph_o[2] = PH_HIGH;  ph_o[1] = PH_LOW;   ph_o[0] = PH_FLOAT; end
            3'b011: begin ph_o[2] = PH_HIGH;  ph_o[1] = PH_FLOAT; ph_o[0] = PH_LOW;   end
            3'b001: begin ph_o[2] = PH_FLOAT; ph_o[1] = PH_HIGH;  ph_o[0] = PH_LOW;   end
            default: begin
                // R5: 000 and 111 leave every phase floating
                ph_o[0] = PH_FLOAT;
                ph_o[1] = PH_FLOAT;
                ph_o[2] = PH_FLOAT;
            end
        endcase
    end

endmodule

// File: rtl/gate_drive.sv
module gate_drive
    import hc_pkg::*;
(
    input  phase_e ph_i,
    input  logic   pwm_i,
    input  logic   rect_i,
    input  logic   permit_i,
    input  logic   therm_i,
    output logic   hi_o,
    output logic   lo_o
);

    logic hi_raw;
    logic lo_raw;

    always_comb begin
        hi_raw = 1'b0;
        lo_raw = 1'b0;
        unique case (ph_i)
            PH_HIGH: begin
                hi_raw = pwm_i;              // R3
                lo_raw = ~pwm_i & rect_i;    // R3
            end
            PH_LOW: begin
                hi_raw = 1'b0;               // R4
                lo_raw = 1'b1;
            end
            PH_FLOAT: begin
                hi_raw = 1'b0;               // R4
                lo_raw = 1'b0;
            end
            default: begin
                hi_raw = 1'b0;
                lo_raw = 1'b0;
            end
        endcase
    end

    // R6: permit gates both sides; R7: thermal fault gates the upper side only
    assign hi_o = hi_raw & permit_i & ~therm_i;
    assign lo_o = lo_raw & permit_i;

endmodule

// File: rtl/hall_commutator.sv
module hall_commutator
    import hc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] filt_len_i,
    input  logic [2:0]       hall_i,
    input  logic             dir_i,
    input  logic             pwm_i,
    input  logic             rect_i,
    input  logic             permit_i,
    input  logic             therm_i,
    output logic [2:0]       hi_en_o,
    output logic [2:0]       lo_en_o
);

    logic [2:0] acc_code;
    phase_e     ph [NUM_PH];

    hall_filter #(.CNT_W(CNT_W)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .len_i  (filt_len_i),
        .hall_i (hall_i),
        .code_o (acc_code)
    );

    comm_decode u_dec (
        .code_i (acc_code),
        .dir_i  (dir_i),
        .ph_o   (ph)
    );

    for (genvar g = 0; g < NUM_PH; g++) begin : g_phase
        gate_drive u_gd (
            .ph_i     (ph[g]),
            .pwm_i    (pwm_i),
            .rect_i   (rect_i),
            .permit_i (permit_i),
            .therm_i  (therm_i),
            .hi_o     (hi_en_o[g]),
            .lo_o     (lo_en_o[g])
        );
    end

endmodule

// File: rtl/hc_checker.sv
module hc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] hall_i,
    input logic       permit_i,
    input logic       therm_i,
    input logic [2:0] hi_en_o,
    input logic [2:0] lo_en_o,
    input logic [2:0] acc_code
);

    a_r11_no_shoot_through: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_en_o & lo_en_o) == 3'b000);

    a_r11_single_upper: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(hi_en_o) <= 1);

    a_r6_permit_off: assert property (@(posedge clk) disable iff (!rst_n)
        !permit_i |-> (hi_en_o == 3'b000 && lo_en_o == 3'b000));

    a_r7_therm_upper_off: assert property (@(posedge clk) disable iff (!rst_n)
        therm_i |-> (hi_en_o == 3'b000));

    a_r5_invalid_off: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_code == 3'b000 || acc_code == 3'b111) |-> (hi_en_o == 3'b000 && lo_en_o == 3'b000));

    a_r8_accept_from_input: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_code != $past(acc_code)) |-> (acc_code == $past(hall_i)));

endmodule

bind hall_commutator hc_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hall_i   (hall_i),
    .permit_i (permit_i),
    .therm_i  (therm_i),
    .hi_en_o  (hi_en_o),
    .lo_en_o  (lo_en_o),
    .acc_code (acc_code)
);

// File: tb/tb_hall_commutator.sv
module tb_hall_commutator;

    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] filt_len_i = 8'd3;
    logic [2:0]       hall_i = 3'b000;
    logic             dir_i = 1'b0;
    logic             pwm_i = 1'b0;
    logic             rect_i = 1'b0;
    logic             permit_i = 1'b0;
    logic             therm_i = 1'b0;
    logic [2:0]       hi_en_o;
    logic [2:0]       lo_en_o;

    int errors = 0;
    int checks = 0;
    logic [2:0] model_acc = 3'b000;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hall_commutator #(.CNT_W(CNT_W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .filt_len_i (filt_len_i),
        .hall_i     (hall_i),
        .dir_i      (dir_i),
        .pwm_i      (pwm_i),
        .rect_i     (rect_i),
        .permit_i   (permit_i),
        .therm_i    (therm_i),
        .hi_en_o    (hi_en_o),
        .lo_en_o    (lo_en_o)
    );

    // Expected {hi[2:0], lo[2:0]} from R1..R7; level code 0=F, 1=H, 2=L
    function automatic logic [5:0] expect_gates(logic [2:0] code, logic dir, logic pwm,
                                                logic rect, logic permit, logic therm);
        logic [2:0] c;
        logic [5:0] lv;
        logic [2:0] hi;
        logic [2:0] lo;
        c = dir ? ~code : code;
        case (c)
            3'b101: lv = {2'd2, 2'd1, 2'd0};
            3'b100: lv = {2'd2, 2'd0, 2'd1};
            3'b110: lv = {2'd0, 2'd2, 2'd1};
            3'b010: lv = {2'd1, 2'd2, 2'd0};
            3'b011: lv = {2'd1, 2'd0, 2'd2};
            3'b001: lv = {2'd0, 2'd1, 2'd2};
            default: lv = 6'd0;
        endcase
        for (int p = 0; p < 3; p++) begin
            case (lv[2*p +: 2])
                2'd1: begin hi[p] = pwm; lo[p] = ~pwm & rect; end
                2'd2: begin hi[p] = 1'b0; lo[p] = 1'b1; end
                default: begin hi[p] = 1'b0; lo[p] = 1'b0; end
            endcase
        end
        if (!permit) begin hi = 3'b000; lo = 3'b000; end
        if (therm) hi = 3'b000;
        return {hi, lo};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string tag);
        logic [5:0] exp_v;
        exp_v = expect_gates(model_acc, dir_i, pwm_i, rect_i, permit_i, therm_i);
        checks++;
        if ({hi_en_o, lo_en_o} !== exp_v) begin
            errors++;
            $display("FAIL %s: hi/lo actual=%b/%b expected=%b/%b (code=%b dir=%b)",
                     tag, hi_en_o, lo_en_o, exp_v[5:3], exp_v[2:0], model_acc, dir_i);
        end
    endtask

    // Apply a code and hold it L edges; checks old state before the L-th edge (R8)
    task automatic settle(logic [2:0] code, int len, string tag);
        hall_i = code;
        if (code != model_acc) begin
            for (int i = 0; i < len - 1; i++) tick();
            check(tag);
            tick();
            model_acc = code;
            check(tag);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        string tag;
        logic [2:0] code;
        int len;
        void'($urandom(32'h5eed_c0de));

        // R10: reset state
        permit_i = 1'b1;
        pwm_i = 1'b1;
        tick(); tick();
        check("R10 in reset");
        rst_n = 1'b1;
        tick();
        check("R10 after reset");

        // R8 / R1 / R3 with L=3
        filt_len_i = 8'd3;
        settle(3'b101, 3, "R8 R1 accept L=3");
        pwm_i = 1'b0; rect_i = 1'b1; #1 check("R3 pwm off rectify");
        rect_i = 1'b0; #1 check("R4 low/float phases");
        pwm_i = 1'b1;

        // R9: glitch shorter than L ignored
        hall_i = 3'b100; tick(); tick();
        hall_i = 3'b101; tick(); check("R9 glitch ignored");
        tick(); tick(); check("R9 glitch ignored later");
        // R9: restart on another code
        hall_i = 3'b100; tick(); tick();
        hall_i = 3'b110; tick(); tick(); check("R9 restart not yet");
        tick(); model_acc = 3'b110; check("R9 restart accepted");

        // R8: length 0 acts as 1
        filt_len_i = 8'd0;
        hall_i = 3'b010; tick(); model_acc = 3'b010; check("R8 len zero");

        // R5: invalid code
        filt_len_i = 8'd2;
        settle(3'b111, 2, "R5 invalid 111");
        settle(3'b011, 2, "R1 code 011");
        dir_i = 1'b1; #1 check("R2 reverse");
        therm_i = 1'b1; #1 check("R7 thermal");
        permit_i = 1'b0; #1 check("R6 permit low");
        permit_i = 1'b1; therm_i = 1'b0; dir_i = 1'b0;

        // Random mix
        for (int it = 0; it < 300; it++) begin
            code = 3'($urandom_range(0, 7));
            len = int'($urandom_range(1, 5));
            filt_len_i = CNT_W'(len);
            settle(code, len, "R8 random accept");
            for (int k = 0; k < 4; k++) begin
                dir_i = 1'($urandom);
                pwm_i = 1'($urandom);
                rect_i = 1'($urandom);
                permit_i = ($urandom_range(0, 7) != 0);
                therm_i = ($urandom_range(0, 7) == 0);
                #1;
                if (!permit_i) tag = "R6 random";
                else if (model_acc == 3'b000 || model_acc == 3'b111) tag = "R5 random";
                else if (therm_i) tag = "R7 random";
                else if (dir_i) tag = "R2 random";
                else tag = "R1 R3 R4 random";
                check(tag);
            end
            permit_i = 1'b1; therm_i = 1'b0;
            tick();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule